// File: doc/BRIEF.md
# Read Request Burst Splitter

This block sits between a DMA engine and a host-memory read port. The engine hands it one read request at a time, as a start byte address and a byte count. The block cuts that request into a series of read bursts. Each burst is no longer than a configured maximum transfer size. When split mode is on, bursts are also cut at a 64-byte line boundary unless they start on a 128-byte boundary. The byte count may be any value, so the last burst can have any length.

Every burst that the downstream port accepts counts as one outstanding read. The block stops offering bursts while the number of outstanding reads equals a configured limit. Each completion pulse returned by the memory side frees one slot. A one-cycle done pulse marks the acceptance of the final burst of a request. The configuration inputs are treated as static while a request is in progress.

Top module: `rd_burst_splitter`

## Requirements
- R1: After reset, req_ready is 1, brst_valid is 0 and req_done is 0, and nothing is outstanding.
- R2: A request is taken only while req_ready is 1. From the cycle after a request with non-zero length is taken, req_ready stays 0 until its final burst has been accepted. A request presented while req_ready is 0 is ignored and does not disturb the bursts in progress.
- R3: cfg_size_sel selects the maximum burst length: 0 gives 64 bytes, 1 gives 128 bytes, 2 and 3 give 256 bytes. With split mode off, every burst is min(remaining bytes, maximum).
- R4: With cfg_split_en at 1, a burst whose address has bits [6:0] equal to zero may be up to the maximum. Any other burst ends at or before the next 64-byte boundary, so its length is at most 64 minus address bits [5:0].
- R5: The first burst starts at the request address. Each later burst starts where the previous one ended. The burst lengths add up exactly to the request length, which need not be a multiple of 4.
- R6: brst_valid is 1 only while the outstanding count is below the effective limit. The outstanding count is the number of accepted bursts minus the number of counted completion pulses.
- R7: The effective limit is cfg_max_out clamped to at most 12. A value of 0 is treated as 1.
- R8: A completion pulse that arrives while nothing is outstanding is ignored.
- R9: req_done pulses for one cycle in the cycle after the final burst is accepted. For a zero-length request it pulses in the cycle after the request is taken, and no burst is issued.
- R10: While brst_valid is 1 and brst_ready is 0, the burst address and length do not change and brst_valid stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_out | input | 4 | Limit on outstanding bursts (clamped to 1..12) |
| cfg_size_sel | input | 2 | Maximum burst size select |
| cfg_split_en | input | 1 | Enables the 64/128-byte alignment rule |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 32 | Request start byte address |
| req_len | input | 16 | Request byte count |
| brst_valid | output | 1 | Burst offered downstream |
| brst_ready | input | 1 | Downstream accepts the burst |
| brst_addr | output | 32 | Burst start byte address |
| brst_len | output | 9 | Burst byte count (1..256) |
| cpl_pulse | input | 1 | One read has completed |
| req_done | output | 1 | Final burst of a request accepted |

## Verification
An error in the address or remaining-length register shows up at the ports on the next burst offered. It appears as a wrong brst_addr, a length that breaks the size or alignment rule, or a final burst that does not close the count, in which case req_done is missing or early. A drifting outstanding counter shows up within the same cycle. brst_valid is then held low although a slot is free, or raised although the window is full. A counter that wraps on a stray completion blocks all further bursts. The bench models the outstanding count and the expected burst sequence on its own, so any of these cases appears as a mismatch on the first affected cycle.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int unsigned MAX_BURST  = 256;
    localparam int unsigned HALF_BYTES = 64;
    localparam int unsigned ALIGN_BYTES = 128;
    localparam int unsigned BLEN_W     = $clog2(MAX_BURST) + 1;
    localparam int unsigned HALF_BITS  = $clog2(HALF_BYTES);
    localparam int unsigned ALIGN_BITS = $clog2(ALIGN_BYTES);

    typedef enum logic [1:0] {
        SZ_64    = 2'd0,
        SZ_128   = 2'd1,
        SZ_256   = 2'd2,
        SZ_256_X = 2'd3
    } size_sel_e;

    function automatic logic [BLEN_W-1:0] cap_of(input logic [1:0] sel);
        logic [BLEN_W-1:0] c;
        case (size_sel_e'(sel))
            SZ_64:   c = BLEN_W'(64);
            SZ_128:  c = BLEN_W'(128);
            default: c = BLEN_W'(256);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rbs_chunk_calc.sv
module rbs_chunk_calc
    import rbs_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic [ALIGN_BITS-1:0] addr_lo,
    input  logic [LEN_W-1:0]      rem,
    input  logic [1:0]            size_sel,
    input  logic                  split_en,
    output logic [BLEN_W-1:0]     chunk_len
);
    logic [BLEN_W-1:0] cap;
    logic [BLEN_W-1:0] room;
    logic [BLEN_W-1:0] lim;
    logic              off_line;

    always_comb begin
        cap      = cap_of(size_sel);
        off_line = |addr_lo;
        room     = BLEN_W'(HALF_BYTES) - BLEN_W'(addr_lo[HALF_BITS-1:0]);
        lim      = (split_en && off_line) ? room : cap;
        if (rem < LEN_W'(lim)) chunk_len = rem[BLEN_W-1:0];
        else                   chunk_len = lim;
    end

endmodule

// File: rtl/rbs_credit_ctr.sv
module rbs_credit_ctr #(
    parameter int unsigned CFG_W    = 4,
    parameter int unsigned HARD_MAX = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_limit,
    input  logic             issue,
    input  logic             retire,
    output logic             can_issue
);
    localparam int unsigned CNT_W = $clog2(HARD_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cred_t;

    cred_t            c_q, c_d;
    logic [CNT_W-1:0] lim;
    logic             drop;

    always_comb begin
        if (int'(cfg_limit) > int'(HARD_MAX)) lim = CNT_W'(HARD_MAX);
        else if (cfg_limit == '0)             lim = CNT_W'(1);
        else                                  lim = CNT_W'(cfg_limit);
        can_issue = c_q.cnt < lim;
        drop      = retire && (c_q.cnt != '0);
        c_d       = c_q;
        c_d.cnt   = c_q.cnt + CNT_W'(issue) - CNT_W'(drop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

endmodule

// File: rtl/rd_burst_splitter.sv
module rd_burst_splitter
    import rbs_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned CFG_W    = 4,
    parameter int unsigned HARD_MAX = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_max_out,
    input  logic [1:0]        cfg_size_sel,
    input  logic              cfg_split_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              brst_valid,
    input  logic              brst_ready,
    output logic [ADDR_W-1:0] brst_addr,
    output logic [BLEN_W-1:0] brst_len,
    input  logic              cpl_pulse,
    output logic              req_done
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic              done;
    } seq_t;

    seq_t              s_q, s_d;
    logic [BLEN_W-1:0] chunk_len;
    logic              can_issue;
    logic              fire;
    logic              last;

    rbs_chunk_calc #(.LEN_W(LEN_W)) u_calc (
        .addr_lo   (s_q.addr[ALIGN_BITS-1:0]),
        .rem       (s_q.rem),
        .size_sel  (cfg_size_sel),
        .split_en  (cfg_split_en),
        .chunk_len (chunk_len)
    );

    rbs_credit_ctr #(.CFG_W(CFG_W), .HARD_MAX(HARD_MAX)) u_cred (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_limit (cfg_max_out),
        .issue     (fire),
        .retire    (cpl_pulse),
        .can_issue (can_issue)
    );

    always_comb begin
        brst_valid = s_q.busy && can_issue;
        fire       = brst_valid && brst_ready;
        last       = (LEN_W'(chunk_len) == s_q.rem);
        s_d        = s_q;
        s_d.done   = 1'b0;
        if (!s_q.busy) begin
            if (req_valid) begin
                if (req_len == '0) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.addr = req_addr;
                    s_d.rem  = req_len;
                end
            end
        end else if (fire) begin
            s_d.addr = s_q.addr + ADDR_W'(chunk_len);
            s_d.rem  = s_q.rem - LEN_W'(chunk_len);
            if (last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = !s_q.busy;
    assign brst_addr = s_q.addr;
    assign brst_len  = chunk_len;
    assign req_done  = s_q.done;

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker
    import rbs_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned CFG_W    = 4,
    parameter int unsigned HARD_MAX = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_W-1:0]  cfg_max_out,
    input logic [1:0]        cfg_size_sel,
    input logic              cfg_split_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LEN_W-1:0]  req_len,
    input logic              brst_valid,
    input logic              brst_ready,
    input logic [ADDR_W-1:0] brst_addr,
    input logic [BLEN_W-1:0] brst_len,
    input logic              cpl_pulse,
    input logic              req_done
);
    int unsigned chk_cnt;
    int unsigned chk_lim;

    always_comb begin
        if (int'(cfg_max_out) > int'(HARD_MAX)) chk_lim = HARD_MAX;
        else if (cfg_max_out == '0)             chk_lim = 1;
        else                                    chk_lim = int'(cfg_max_out);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chk_cnt <= 0;
        else chk_cnt <= chk_cnt + ((brst_valid && brst_ready) ? 1 : 0)
                                - ((cpl_pulse && chk_cnt != 0) ? 1 : 0);
    end

    AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        brst_valid |-> (chk_cnt < chk_lim)); // R6 R8

    AST_LIMIT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        brst_valid |-> (chk_cnt < HARD_MAX)); // R7

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        brst_valid |-> (brst_len != '0 && brst_len <= cap_of(cfg_size_sel))); // R3

    AST_SPLIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (brst_valid && cfg_split_en && (|brst_addr[ALIGN_BITS-1:0]))
        |-> ((BLEN_W'(brst_addr[HALF_BITS-1:0]) + brst_len) <= BLEN_W'(HALF_BYTES))); // R4

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (brst_valid && !brst_ready)
        |=> (brst_valid && $stable(brst_addr) && $stable(brst_len))); // R10

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len != '0) |=> !req_ready); // R2

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> ($past(brst_valid && brst_ready)
                      || $past(req_valid && req_ready && req_len == '0))); // R9

endmodule

bind rd_burst_splitter rbs_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CFG_W(CFG_W), .HARD_MAX(HARD_MAX)
) u_rbs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_max_out  (cfg_max_out),
    .cfg_size_sel (cfg_size_sel),
    .cfg_split_en (cfg_split_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_len      (req_len),
    .brst_valid   (brst_valid),
    .brst_ready   (brst_ready),
    .brst_addr    (brst_addr),
    .brst_len     (brst_len),
    .cpl_pulse    (cpl_pulse),
    .req_done     (req_done)
);

// File: tb/rd_burst_splitter_bench.sv
module rd_burst_splitter_bench;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int CFG_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CFG_W-1:0]  cfg_max_out = 4'd4;
    logic [1:0]        cfg_size_sel = 2'd0;
    logic              cfg_split_en = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              brst_valid;
    logic              brst_ready = 1'b0;
    logic [ADDR_W-1:0] brst_addr;
    logic [8:0]        brst_len;
    logic              cpl_pulse = 1'b0;
    logic              req_done;

    int n_chk = 0;
    int n_fail = 0;
    int out_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rd_burst_splitter u_rd_burst_splitter (
        .clk(clk), .rst_n(rst_n), .cfg_max_out(cfg_max_out),
        .cfg_size_sel(cfg_size_sel), .cfg_split_en(cfg_split_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .brst_valid(brst_valid), .brst_ready(brst_ready),
        .brst_addr(brst_addr), .brst_len(brst_len), .cpl_pulse(cpl_pulse),
        .req_done(req_done)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int eff_lim(input int c);
        if (c > 12) return 12;   // R7 clamp
        if (c == 0) return 1;
        return c;
    endfunction

    function automatic int exp_len(input logic [31:0] a, input int rem, input int sel, input bit sp);
        int cap;
        int lim;
        cap = (sel == 0) ? 64 : (sel == 1) ? 128 : 256;
        if (sp && a[6:0] != 7'd0) lim = 64 - int'(a[5:0]);
        else                      lim = cap;
        return (rem < lim) ? rem : lim;
    endfunction

    task automatic run_req(input logic [31:0] a, input int len, input int rdy_pct, input int cpl_pct);
        logic [31:0] ea;
        int er;
        int el;
        bit stalled;
        bit rdy;
        bit cpl;
        @(negedge clk);
        chk("R2", "req_ready while idle", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        if (len == 0) begin
            chk("R9", "done after zero-length request", req_done, 1);
            chk("R9", "no burst for zero length", brst_valid, 0);
            chk("R2", "ready after zero length", req_ready, 1);
            return;
        end
        ea = a;
        er = len;
        stalled = 1'b0;
        el = 0;
        while (er > 0) begin
            chk("R9", "no done mid-request", req_done, 0);
            chk("R2", "busy blocks requests", req_ready, 0);
            chk("R6", "burst offered vs window", brst_valid, (out_cnt < eff_lim(int'(cfg_max_out))) ? 1 : 0);
            if (brst_valid) begin
                el = exp_len(ea, er, int'(cfg_size_sel), cfg_split_en);
                chk(stalled ? "R10" : "R5", "burst address", brst_addr, ea);
                chk(stalled ? "R10" : (cfg_split_en ? "R4" : "R3"), "burst length", brst_len, el);
            end
            rdy = ($urandom % 100) < rdy_pct;
            cpl = (out_cnt > 0) && (($urandom % 100) < cpl_pct);
            brst_ready = rdy;
            cpl_pulse  = cpl;
            req_valid  = $urandom % 2;          // R2 noise while busy
            req_addr   = $urandom;
            req_len    = LEN_W'($urandom % 300);
            if (brst_valid && rdy) begin
                out_cnt++;
                ea = ea + 32'(el);
                er = er - el;
            end
            if (cpl) out_cnt--;
            stalled = brst_valid && !rdy;
            @(negedge clk);
        end
        brst_ready = 1'b0;
        cpl_pulse  = 1'b0;
        req_valid  = 1'b0;
        chk("R9", "done after final burst", req_done, 1);
        chk("R2", "ready after final burst", req_ready, 1);
        chk("R5", "no burst past length", brst_valid, 0);
    endtask

    task automatic drain();
        while (out_cnt > 0) begin
            @(negedge clk);
            cpl_pulse = 1'b1;
            out_cnt--;
        end
        @(negedge clk);
        cpl_pulse = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1f2e_3d4c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready after reset", req_ready, 1);
        chk("R1", "brst_valid after reset", brst_valid, 0);
        chk("R1", "req_done after reset", req_done, 0);

        // R3: 64-byte bursts, odd address and length
        cfg_max_out = 4'd12; cfg_size_sel = 2'd0; cfg_split_en = 1'b0;
        run_req(32'h0000_1003, 201, 100, 100);
        drain();
        // R4: split with 128-byte size, start on 64 but not 128 alignment
        cfg_size_sel = 2'd1; cfg_split_en = 1'b1;
        run_req(32'h0000_1040, 300, 100, 100);
        run_req(32'h0000_10FE, 5, 100, 100);
        drain();
        // R3: 256-byte size, sel 3 also 256, split off
        cfg_size_sel = 2'd3; cfg_split_en = 1'b0;
        run_req(32'h0000_2005, 1000, 80, 60);
        drain();
        // R9: zero-length request
        run_req(32'h0000_3000, 0, 100, 100);
        // R7: limit above 12 clamps to 12, completions scarce
        cfg_max_out = 4'd15; cfg_size_sel = 2'd0;
        run_req(32'h0000_4000, 1800, 100, 5);
        drain();
        // R7: limit 0 acts as 1
        cfg_max_out = 4'd0; cfg_size_sel = 2'd2; cfg_split_en = 1'b1;
        run_req(32'h0000_5033, 700, 90, 50);
        drain();
        // R8: stray completions while nothing outstanding
        cfg_max_out = 4'd2;
        @(negedge clk); cpl_pulse = 1'b1;
        @(negedge clk); @(negedge clk); cpl_pulse = 1'b0;
        run_req(32'h0000_6000, 400, 100, 30);
        drain();
        // mixed random stimulus
        for (int i = 0; i < 40; i++) begin
            cfg_max_out  = CFG_W'($urandom % 16);
            cfg_size_sel = 2'($urandom % 4);
            cfg_split_en = $urandom % 2;
            run_req(($urandom & 32'h0FFF_FFFF), int'($urandom % 701),
                    30 + int'($urandom % 71), 20 + int'($urandom % 61));
            if (($urandom % 4) == 0) drain();
        end
        drain();
        finish_run();
    end
endmodule